// File: doc/BRIEF.md
# Terminal Line Capture Port

This block sits on a small port-mapped bus and gathers one line of text from a terminal byte stream without any per-character work from the processor. Each byte presented on the receive handshake carries a 7-bit character in its low bits and an even-parity bit in bit 7. The engine checks the parity and clears the top bit. It then writes the character into an internal 82-byte line store. Capture stops when a carriage return arrives, when a parity error is seen, or when the store fills.

When the line ends with a carriage return, a line feed is added after it on the next cycle and the line is reported complete. If 81 characters arrive with no return, the block raises an overflow. It then sends a fixed warning text, "OVERRUN" followed by CR and LF, out through the same transmit holding register that the processor uses. The processor can see the status bits, the character count and the stored line through four port addresses. Writing to the status port arms the engine for a new line.

Top module: `line_capture_port`

## Requirements
- R1: After a synchronous reset the count reads 0, status reads 01h (transmit holding free, no other bit set), and the receive handshake `rxReady` is high.
- R2: Port map: 52h reads the next stored character, 53h is written with a byte to transmit, 54h reads status and is written to re-arm, and 55h reads the character count. A read returns its data on `ioRdData` from the clock edge that samples `ioRd`. Any other address reads 00h.
- R3: A received byte whose eight bits hold an odd number of ones sets the parity-error status bit (bit 4), is not stored, and stops capture. A byte with even parity is stored with bit 7 cleared.
- R4: A stored carriage return (0Dh) is followed on the next cycle by a stored line feed (0Ah), and both are counted. Status bit 2 (line complete) is then set. A return that arrives as the 81st character still completes the line, and the count is 82.
- R5: Once capture has ended, `rxReady` stays low and offered bytes are neither stored nor counted.
- R6: When the 81st character is stored and it is not a carriage return, status bit 3 (overflow) is set, the count stays at 81, and capture stops.
- R7: After an overflow, the nine bytes 4Fh 56h 45h 52h 52h 55h 4Eh 0Dh 0Ah leave in that order through the transmit handshake.
- R8: Status bit 0 is high while the transmit holding register is empty. Bit 1 is high when capture has ended and unread characters remain. Bits 2 to 4 stay set until a status read, and that read returns them and then clears them. If a set and a clear fall in the same cycle, the set wins.
- R9: A write to 53h while the holding register is empty loads it, and `txValid` then stays high with `txData` stable until `txReady` is high. A write while it is full is dropped. If the overflow text and a processor write compete for the register, the overflow text wins.
- R10: A read of 52h while status bit 1 is set returns the next stored character and advances the read pointer. Otherwise the read returns 00h and the pointer does not move.
- R11: A write to 54h clears the count and the read pointer and restarts capture. It leaves the sticky status bits unchanged and drops any receive byte offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ioAddr | input | 8 | Port address |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Registered read data |
| rxValid | input | 1 | Receive byte offered |
| rxByte | input | 8 | Received byte, bit 7 is parity |
| rxReady | output | 1 | Engine takes a byte this cycle if rxValid |
| txValid | output | 1 | Transmit holding register full |
| txData | output | 8 | Byte to transmit |
| txReady | input | 1 | Transmit side accepts the byte |

## Verification
A short line ending in a return is sent to show the appended line feed, the count and the clearing of the top bit. A line of 80 characters followed by a return checks the last slot, where completion must win over overflow. A run of 81 plain characters must instead give an overflow and the warning text. A byte with bad parity set in its top bit is also offered, and separates a dropped byte and stopped capture from a stored one. A behavioural model that keeps the line in a queue is compared with the read data, the receive handshake and the transmit handshake on every cycle. This also catches timing slips that the scenario checks alone would miss.

// File: rtl/lcp_pkg.sv
package lcp_pkg;

  localparam int MSG_LEN = 9;

  typedef enum logic [1:0] {
    ST_CAP,
    ST_LF,
    ST_MSG,
    ST_END
  } capState_t;

  typedef struct packed {
    logic       storeRx;
    logic       storeLf;
    logic       rearm;
    logic       popRd;
    logic       loadMsg;
    logic       loadCpu;
    logic [7:0] msgByte;
  } lcpStrobe_t;

  function automatic logic [7:0] warnChar(input logic [3:0] idx);
    case (idx)
      4'd0:    warnChar = 8'h4F;
      4'd1:    warnChar = 8'h56;
      4'd2:    warnChar = 8'h45;
      4'd3:    warnChar = 8'h52;
      4'd4:    warnChar = 8'h52;
      4'd5:    warnChar = 8'h55;
      4'd6:    warnChar = 8'h4E;
      4'd7:    warnChar = 8'h0D;
      default: warnChar = 8'h0A;
    endcase
  endfunction

endpackage

// File: rtl/lcp_ctrl.sv
module lcp_ctrl
  import lcp_pkg::*;
#(
  parameter int BUF_DEPTH = 82,
  parameter logic [7:0] ADDR_DIN  = 8'h52,
  parameter logic [7:0] ADDR_DOUT = 8'h53,
  parameter logic [7:0] ADDR_STAT = 8'h54,
  localparam int CW = $clog2(BUF_DEPTH + 1),
  localparam int MAX_CHARS = BUF_DEPTH - 1
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    ioAddr,
  input  logic          ioRd,
  input  logic          ioWr,
  input  logic          rxValid,
  input  logic [7:0]    rxByte,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] rdPtr,
  input  logic          txFull,
  output logic          rxReady,
  output logic [7:0]    statusByte,
  output lcpStrobe_t    stb
);

  capState_t state, stateNext;
  logic [3:0] msgIdx;
  logic lineQ, ovfQ, parQ;
  logic rearm, accept, parOdd, isCr, lastSlot, avail, statRd;

  assign rearm    = ioWr && (ioAddr == ADDR_STAT);
  assign statRd   = ioRd && (ioAddr == ADDR_STAT);
  assign rxReady  = (state == ST_CAP) && !rearm;
  assign accept   = rxReady && rxValid;
  assign parOdd   = ^rxByte;
  assign isCr     = (rxByte[6:0] == 7'h0D);
  assign lastSlot = (count == CW'(MAX_CHARS - 1));
  assign avail    = ((state == ST_END) || (state == ST_MSG)) && (rdPtr < count);
  assign statusByte = {3'b000, parQ, ovfQ, lineQ, avail, ~txFull};

  always_comb begin
    stb         = '0;
    stb.rearm   = rearm;
    stb.storeRx = accept && !parOdd;
    stb.storeLf = (state == ST_LF) && !rearm;
    stb.popRd   = ioRd && (ioAddr == ADDR_DIN) && avail;
    stb.loadMsg = (state == ST_MSG) && !txFull && !rearm;
    stb.loadCpu = ioWr && (ioAddr == ADDR_DOUT) && !txFull && !stb.loadMsg;
    stb.msgByte = warnChar(msgIdx);
  end

  always_comb begin
    stateNext = state;
    if (rearm) stateNext = ST_CAP;
    else begin
      case (state)
        ST_CAP: if (accept) begin
          if (parOdd)        stateNext = ST_END;
          else if (isCr)     stateNext = ST_LF;
          else if (lastSlot) stateNext = ST_MSG;
        end
        ST_LF:  stateNext = ST_END;
        ST_MSG: if (stb.loadMsg && (msgIdx == 4'(MSG_LEN - 1))) stateNext = ST_END;
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_CAP;
      msgIdx <= '0;
      lineQ  <= 1'b0;
      ovfQ   <= 1'b0;
      parQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (rearm)            msgIdx <= '0;
      else if (stb.loadMsg) msgIdx <= msgIdx + 4'd1;
      lineQ <= (lineQ && !statRd) || stb.storeLf;
      ovfQ  <= (ovfQ && !statRd) || (stb.storeRx && !isCr && lastSlot);
      parQ  <= (parQ && !statRd) || (accept && parOdd);
    end
  end

  // R6: overflow only rises with exactly the maximum number of characters held
  assert_ovf_count_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovfQ) |-> (count == CW'(MAX_CHARS)));

  // R4: line-complete rises only as capture ends
  assert_line_end_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(lineQ) |-> (state == ST_END));

  // R5: no byte is taken once capture has stopped
  assert_no_take_after_end_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_END && !rearm) |=> $stable(count) || $past(stb.rearm) || stb.rearm || (count == '0));

endmodule

// File: rtl/lcp_datapath.sv
module lcp_datapath
  import lcp_pkg::*;
#(
  parameter int BUF_DEPTH = 82,
  parameter logic [7:0] ADDR_DIN  = 8'h52,
  parameter logic [7:0] ADDR_STAT = 8'h54,
  parameter logic [7:0] ADDR_CNT  = 8'h55,
  localparam int CW = $clog2(BUF_DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst,
  input  lcpStrobe_t    stb,
  input  logic [7:0]    ioAddr,
  input  logic          ioRd,
  input  logic [7:0]    ioWrData,
  input  logic [7:0]    rxByte,
  input  logic [7:0]    statusByte,
  input  logic          txReady,
  output logic [CW-1:0] count,
  output logic [CW-1:0] rdPtr,
  output logic          txFull,
  output logic [7:0]    txHold,
  output logic [7:0]    ioRdData
);

  logic [7:0] bufMem [BUF_DEPTH];

  always_ff @(posedge clk) begin
    if (stb.storeRx && !stb.rearm) bufMem[count] <= {1'b0, rxByte[6:0]};
    else if (stb.storeLf)          bufMem[count] <= 8'h0A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      rdPtr <= '0;
    end else if (stb.rearm) begin
      count <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.storeRx || stb.storeLf) count <= count + 1'b1;
      if (stb.popRd)                  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txFull <= 1'b0;
      txHold <= '0;
    end else if (stb.loadMsg) begin
      txFull <= 1'b1;
      txHold <= stb.msgByte;
    end else if (stb.loadCpu) begin
      txFull <= 1'b1;
      txHold <= ioWrData;
    end else if (txFull && txReady) begin
      txFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ioRdData <= '0;
    else if (ioRd) begin
      if (ioAddr == ADDR_DIN)       ioRdData <= stb.popRd ? bufMem[rdPtr] : 8'h00;
      else if (ioAddr == ADDR_STAT) ioRdData <= statusByte;
      else if (ioAddr == ADDR_CNT)  ioRdData <= 8'(count);
      else                          ioRdData <= 8'h00;
    end
  end

  // R4/R6: the count never passes the store depth
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(BUF_DEPTH));

  // R9: a waiting transmit byte holds until taken
  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (txFull && !txReady) |=> (txFull && $stable(txHold)));

  // R3: a stored receive character has its top bit cleared
  assert_top_bit_clear_R3: assert property (@(posedge clk) disable iff (rst)
    stb.storeRx |=> (bufMem[count - 1'b1][7] == 1'b0));

endmodule

// File: rtl/line_capture_port.sv
module line_capture_port
  import lcp_pkg::*;
#(
  parameter int BUF_DEPTH = 82,
  parameter logic [7:0] ADDR_DIN  = 8'h52,
  parameter logic [7:0] ADDR_DOUT = 8'h53,
  parameter logic [7:0] ADDR_STAT = 8'h54,
  parameter logic [7:0] ADDR_CNT  = 8'h55,
  localparam int CW = $clog2(BUF_DEPTH + 1)
)(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] ioAddr,
  input  logic       ioRd,
  input  logic       ioWr,
  input  logic [7:0] ioWrData,
  output logic [7:0] ioRdData,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  output logic       rxReady,
  output logic       txValid,
  output logic [7:0] txData,
  input  logic       txReady
);

  lcpStrobe_t    stb;
  logic [CW-1:0] count, rdPtr;
  logic          txFull;
  logic [7:0]    statusByte;

  lcp_ctrl #(
    .BUF_DEPTH(BUF_DEPTH), .ADDR_DIN(ADDR_DIN),
    .ADDR_DOUT(ADDR_DOUT), .ADDR_STAT(ADDR_STAT)
  ) uCtrl (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .rxValid(rxValid), .rxByte(rxByte), .count(count), .rdPtr(rdPtr),
    .txFull(txFull), .rxReady(rxReady), .statusByte(statusByte), .stb(stb)
  );

  lcp_datapath #(
    .BUF_DEPTH(BUF_DEPTH), .ADDR_DIN(ADDR_DIN),
    .ADDR_STAT(ADDR_STAT), .ADDR_CNT(ADDR_CNT)
  ) uData (
    .clk(clk), .rst(rst), .stb(stb), .ioAddr(ioAddr), .ioRd(ioRd),
    .ioWrData(ioWrData), .rxByte(rxByte), .statusByte(statusByte),
    .txReady(txReady), .count(count), .rdPtr(rdPtr), .txFull(txFull),
    .txHold(txData), .ioRdData(ioRdData)
  );

  assign txValid = txFull;

endmodule

// File: tb/tb_line_capture_port.sv
module tb_line_capture_port;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] ioAddr = '0, ioWrData = '0, rxByte = '0;
  logic ioRd = 1'b0, ioWr = 1'b0, rxValid = 1'b0, txReady = 1'b1;
  logic [7:0] ioRdData, txData;
  logic rxReady, txValid;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] txLog[$];

  // behavioural reference state
  int mMode = 0;            // 0 capture, 1 LF pending, 2 warning text, 3 ended
  logic [7:0] mLine[$];
  int rdIdx = 0, msgPos = 0;
  bit hFull = 0, fLine = 0, fOvf = 0, fPar = 0;
  logic [7:0] hData = '0, eRd = '0;
  bit finished = 0;

  line_capture_port dut (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .rxValid(rxValid),
    .rxByte(rxByte), .rxReady(rxReady), .txValid(txValid),
    .txData(txData), .txReady(txReady)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] warn(int i);
    logic [7:0] t [9] = '{8'h4F, 8'h56, 8'h45, 8'h52, 8'h52, 8'h55, 8'h4E, 8'h0D, 8'h0A};
    return t[i];
  endfunction

  function automatic logic [7:0] withPar(logic [6:0] c);
    return {^c, c};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (txValid && txReady && !rst) txLog.push_back(txData);
    if (rst) begin
      mMode = 0; mLine.delete(); rdIdx = 0; msgPos = 0;
      hFull = 0; hData = '0; fLine = 0; fOvf = 0; fPar = 0; eRd = '0;
    end else begin
      bit rearm, avail, msgLoad, accept;
      logic [7:0] st;
      rearm   = ioWr && ioAddr == 8'h54;
      avail   = (mMode == 2 || mMode == 3) && rdIdx < mLine.size();
      st      = {3'b000, fPar, fOvf, fLine, avail, !hFull};
      accept  = mMode == 0 && rxValid && !rearm;
      msgLoad = mMode == 2 && !hFull && !rearm;
      if (ioRd) begin
        if (ioAddr == 8'h52) begin
          if (avail) begin eRd = mLine[rdIdx]; rdIdx++; end else eRd = 8'h00;
        end else if (ioAddr == 8'h54) begin
          eRd = st; fLine = 0; fOvf = 0; fPar = 0;
        end else if (ioAddr == 8'h55) eRd = 8'(mLine.size());
        else eRd = 8'h00;
      end
      if (msgLoad) begin hData = warn(msgPos); hFull = 1; msgPos++; end
      else if (ioWr && ioAddr == 8'h53 && !hFull) begin hData = ioWrData; hFull = 1; end
      else if (hFull && txReady) hFull = 0;
      if (rearm) begin
        mLine.delete(); rdIdx = 0; mMode = 0; msgPos = 0;
      end else if (mMode == 0 && accept) begin
        if (^rxByte) begin fPar = 1; mMode = 3; end
        else begin
          mLine.push_back({1'b0, rxByte[6:0]});
          if (rxByte[6:0] == 7'h0D) mMode = 1;
          else if (mLine.size() == 81) begin fOvf = 1; mMode = 2; end
        end
      end else if (mMode == 1) begin
        mLine.push_back(8'h0A); fLine = 1; mMode = 3;
      end else if (mMode == 2 && msgLoad && msgPos == 9) mMode = 3;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 read data", ioRdData, eRd);
      chk("R5 rxReady", {7'b0, rxReady}, {7'b0, mMode == 0 && !(ioWr && ioAddr == 8'h54)});
      chk("R9 txValid", {7'b0, txValid}, {7'b0, hFull});
      if (hFull) chk("R9 txData", txData, hData);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      wrapUp();
    end
  end

  task automatic ioRead(input logic [7:0] a, output logic [7:0] v);
    @(posedge clk); #1 ioAddr = a; ioRd = 1'b1;
    @(posedge clk); #1 ioRd = 1'b0;
    @(negedge clk); v = ioRdData;
  endtask

  task automatic ioWrite(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1 ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(posedge clk); #1 ioWr = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(posedge clk); #1 rxValid = 1'b1; rxByte = b;
    @(posedge clk); #1 rxValid = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk); chk("R1 rxReady", {7'b0, rxReady}, 8'h01);
    ioRead(8'h54, v); chk("R1 status", v, 8'h01);
    ioRead(8'h55, v); chk("R1 count", v, 8'h00);
    ioRead(8'h60, v); chk("R2 unmapped", v, 8'h00);

    // R4 short line ending in a return with a parity bit set
    sendByte(withPar(7'h48)); sendByte(withPar(7'h69)); sendByte(withPar(7'h0D));
    repeat (2) @(posedge clk);
    ioRead(8'h55, v); chk("R4 count", v, 8'h04);
    ioRead(8'h54, v); chk("R8 status sticky", v, 8'h07);
    ioRead(8'h54, v); chk("R8 status cleared", v, 8'h03);
    ioRead(8'h52, v); chk("R10 char0", v, 8'h48);
    ioRead(8'h52, v); chk("R10 char1", v, 8'h69);
    ioRead(8'h52, v); chk("R3 cr top bit cleared", v, 8'h0D);
    ioRead(8'h52, v); chk("R4 appended lf", v, 8'h0A);
    ioRead(8'h52, v); chk("R10 empty read", v, 8'h00);
    ioRead(8'h54, v); chk("R8 no unread", v, 8'h01);

    // R3 parity error, R5 capture stopped, R11 re-arm keeps flags
    ioWrite(8'h54, 8'h00);
    sendByte(withPar(7'h61));
    sendByte(8'hC1);
    sendByte(withPar(7'h62));
    ioRead(8'h55, v); chk("R3 bad byte dropped", v, 8'h01);
    chk("R5 rxReady low", {7'b0, rxReady}, 8'h00);
    ioRead(8'h52, v); chk("R3 stored char", v, 8'h61);
    ioWrite(8'h54, 8'h00);
    ioRead(8'h54, v); chk("R11 flag kept", v, 8'h11);
    ioRead(8'h55, v); chk("R11 count cleared", v, 8'h00);

    // R4 boundary: return as the 81st character
    for (int i = 0; i < 80; i++) sendByte(withPar(7'h41 + 7'(i % 26)));
    sendByte(withPar(7'h0D));
    repeat (2) @(posedge clk);
    ioRead(8'h55, v); chk("R4 full line count", v, 8'd82);
    ioRead(8'h54, v); chk("R4 complete not overflow", v, 8'h07);

    // R6 overflow and R7 warning text
    ioWrite(8'h54, 8'h00);
    txLog.delete();
    for (int i = 0; i < 81; i++) sendByte(withPar(7'h61 + 7'(i % 26)));
    sendByte(withPar(7'h0D));
    repeat (30) @(posedge clk);
    ioRead(8'h55, v); chk("R6 count", v, 8'd81);
    ioRead(8'h54, v); chk("R6 status", v, 8'h0B);
    chk("R7 text length", 8'(txLog.size()), 8'd9);
    for (int i = 0; i < 9; i++)
      if (i < txLog.size()) chk("R7 text byte", txLog[i], warn(i));

    // R9 processor transmit with back-pressure
    ioWrite(8'h54, 8'h00);
    repeat (2) @(posedge clk);
    #1 txReady = 1'b0;
    txLog.delete();
    ioWrite(8'h53, 8'h5A);
    ioWrite(8'h53, 8'h33);
    ioRead(8'h54, v); chk("R9 holding busy", v, 8'h00);
    repeat (3) @(posedge clk);
    #1 txReady = 1'b1;
    repeat (3) @(posedge clk);
    chk("R9 one byte sent", 8'(txLog.size()), 8'd1);
    if (txLog.size() > 0) chk("R9 byte value", txLog[0], 8'h5A);

    repeat (2) @(posedge clk);
    wrapUp();
  end

endmodule